// File: doc/BRIEF.md
# Trimmed Low-Speed Time Base

This block divides a 32.768 kHz low-speed clock through a binary counter chain and issues single-cycle tick pulses at every power-of-two rate from 4096 Hz down to 1 Hz. Capture logic and interrupt sources elsewhere sample these ticks, so the 4096 Hz to 32 Hz taps must always be present.

Crystals run slightly fast or slow. To correct for this, software loads a signed trim value. Over a fixed window of input clocks, the block then adds or removes that many counts from the chain. An accumulator spreads the adjustments evenly across the window. With the default widths, the trim value is 11 bits and the window is 2^21 clocks. One trim step is then about 0.477 ppm, and the full range is about ±488 ppm. A clear strobe restarts the chain at zero and leaves the loaded trim untouched.

Top module: `tbc_lowspeed`

## Requirements
- R1: After reset, all tick outputs are low, the divider chain holds zero, trimming is disabled and the stored trim value is zero.
- R2: tick_o[k] is a one-cycle pulse. It is high in the cycle after the edge at which divider bit TAP_LO+k goes from 0 to 1. With the defaults, tick_o[0] is 4096 Hz (bit 2) and tick_o[12] is 1 Hz (bit 14).
- R3: While trimming is disabled, the divider advances by exactly one per clock.
- R4: A clock edge with wr_i high loads wr_corr_i (two's complement) and wr_trim_en_i, and clears the trim accumulator.
- R5: While trimming is enabled, each clock adds |trim| to an accumulator that wraps at 2^WIN_W, and each wrap causes one adjustment. Over the n clocks after a write, exactly floor(n*|trim|/2^WIN_W) adjustments occur, no two of them on consecutive clocks, and none on the first clock.
- R6: An adjustment with a positive trim advances the divider by two on that clock, inserting a count. With a negative trim, the divider holds for that clock, swallowing a count. A zero trim causes no adjustment.
- R7: A clock edge with clr_i high sets the whole divider chain to zero, produces no tick, and leaves the trim value, enable and accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Trim register write strobe |
| wr_corr_i | input | CORR_W | Signed trim value to load |
| wr_trim_en_i | input | 1 | Trim enable to load |
| clr_i | input | 1 | Divider chain clear strobe |
| tick_o | output | N_TAPS | Tick pulses, bit 0 fastest |

## Verification
The bench uses a short window and a narrow trim value. It sweeps every trim value over a run length that is not a window multiple, and counts the ticks on every tap against an arithmetic expectation. This catches a design that bunches or miscounts adjustments, inverts the sign, or mishandles the most negative value: each of these shifts some tap's count. A run with trimming disabled shows whether the enable is respected. A clear issued in mid-run, with no write, exposes a design that wipes the accumulator or drops the trim on clear, because the counts that follow would drift from the expected values. Counting from reset checks the idle state and the untrimmed rate.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;
endpackage

// File: rtl/tbc_trim_acc.sv
module tbc_trim_acc
  import tbc_pkg::*;
#(
  parameter int CORR_W = 11,
  parameter int WIN_W  = 21   // must be >= CORR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CORR_W-1:0] wr_corr_i,
  input  logic              wr_trim_en_i,
  output step_e             step_o
);
  logic [CORR_W-1:0] corr_q;
  logic              en_q;
  logic [WIN_W-1:0]  acc_q;
  logic [CORR_W-1:0] mag;
  logic [WIN_W:0]    sum;
  logic              wrap;

  // magnitude; the most negative value maps to 2^(CORR_W-1) unsigned
  assign mag  = corr_q[CORR_W-1] ? (~corr_q + CORR_W'(1)) : corr_q;
  assign sum  = {1'b0, acc_q} + (WIN_W+1)'(mag);
  assign wrap = en_q & sum[WIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= '0;
      en_q   <= 1'b0;
      acc_q  <= '0;
    end else if (wr_i) begin
      corr_q <= wr_corr_i;
      en_q   <= wr_trim_en_i;
      acc_q  <= '0;
    end else if (en_q) begin
      acc_q  <= sum[WIN_W-1:0];
    end
  end

  always_comb begin
    if (!wrap)                  step_o = STEP_ONE;
    else if (corr_q[CORR_W-1])  step_o = STEP_HOLD;
    else                        step_o = STEP_TWO;
  end
endmodule

// File: rtl/tbc_div.sv
module tbc_div
  import tbc_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  step_e            step_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic [DIV_W-1:0] div_d_o
);
  logic [DIV_W-1:0] div_q;

  assign div_d_o = clr_i ? '0 : div_q + DIV_W'(step_i);
  assign div_q_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d_o;
  end
endmodule

// File: rtl/tbc_tick_gen.sv
module tbc_tick_gen #(
  parameter int N_TAPS = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TAPS-1:0] cur_i,
  input  logic [N_TAPS-1:0] nxt_i,
  output logic [N_TAPS-1:0] tick_o
);
  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_o[k] <= 1'b0;
      else         tick_o[k] <= nxt_i[k] & ~cur_i[k];
    end
  end
endmodule

// File: rtl/tbc_lowspeed.sv
module tbc_lowspeed
  import tbc_pkg::*;
#(
  parameter int CORR_W = 11,
  parameter int WIN_W  = 21,
  parameter int TAP_LO = 2,
  parameter int N_TAPS = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CORR_W-1:0] wr_corr_i,
  input  logic              wr_trim_en_i,
  input  logic              clr_i,
  output logic [N_TAPS-1:0] tick_o
);
  localparam int DIV_W = TAP_LO + N_TAPS;

  step_e            step;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  tbc_trim_acc #(.CORR_W(CORR_W), .WIN_W(WIN_W)) i_trim (
    .clk_i, .rst_ni, .wr_i, .wr_corr_i, .wr_trim_en_i,
    .step_o(step)
  );

  tbc_div #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni, .clr_i,
    .step_i (step),
    .div_q_o(div_q),
    .div_d_o(div_d)
  );

  tbc_tick_gen #(.N_TAPS(N_TAPS)) i_tick (
    .clk_i, .rst_ni,
    .cur_i (div_q[DIV_W-1:TAP_LO]),
    .nxt_i (div_d[DIV_W-1:TAP_LO]),
    .tick_o
  );
endmodule

// File: rtl/tbc_lowspeed_chk.sv
module tbc_lowspeed_chk
  import tbc_pkg::*;
#(
  parameter int N_TAPS = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              clr_i,
  input logic [N_TAPS-1:0] tick_o,
  input step_e             step_i
);
  // R2
  tick_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o != '0) |=> ((tick_o & $past(tick_o)) == '0));

  // R7
  clr_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tick_o == '0));

  // R4
  wr_restarts_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (step_i == STEP_ONE));

  // R5
  adj_spread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != STEP_ONE) |=> (step_i == STEP_ONE));
endmodule

bind tbc_lowspeed tbc_lowspeed_chk #(.N_TAPS(N_TAPS)) i_tbc_lowspeed_chk (
  .clk_i, .rst_ni, .wr_i, .clr_i, .tick_o,
  .step_i(step)
);

// File: tb/test_tbc_lowspeed.sv
module test_tbc_lowspeed;
  localparam int CLK_PERIOD = 10;
  localparam int CORR_W = 6;
  localparam int WIN_W  = 8;
  localparam int TAP_LO = 2;
  localparam int N_TAPS = 6;
  localparam int RUN_N  = 300;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0;
  logic [CORR_W-1:0] wr_corr_i = '0;
  logic              wr_trim_en_i = 1'b0;
  logic              clr_i = 1'b0;
  logic [N_TAPS-1:0] tick_o;

  int n_chk = 0;
  int n_bad = 0;
  int cnt [N_TAPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbc_lowspeed #(.CORR_W(CORR_W), .WIN_W(WIN_W), .TAP_LO(TAP_LO), .N_TAPS(N_TAPS))
    i_tbc_lowspeed (.clk_i(clk), .rst_ni, .wr_i, .wr_corr_i, .wr_trim_en_i, .clr_i, .tick_o);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rising edges of bit b while counting 0..v
  function automatic int edges(input int v, input int b);
    return (v + (1 << b)) / (1 << (b + 1));
  endfunction

  task automatic count_ticks(input int n);
    for (int k = 0; k < N_TAPS; k++) cnt[k] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < N_TAPS; k++) cnt[k] += int'(tick_o[k]);
    end
  endtask

  task automatic check_taps(input string req, input int v);
    for (int k = 0; k < N_TAPS; k++) chk(req, cnt[k], edges(v, TAP_LO + k));
  endtask

  // write trim and clear divider together, then count
  task automatic run_trim(input int c, input bit en, input int n);
    int mag, adj, v;
    @(negedge clk);
    wr_i = 1'b1; wr_corr_i = CORR_W'(c); wr_trim_en_i = en; clr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; clr_i = 1'b0;
    mag = (c < 0) ? -c : c;
    adj = en ? (n * mag) / (1 << WIN_W) : 0;
    v = (c < 0) ? n - adj : n + adj;
    count_ticks(n);
    if (!en)       check_taps("R3", v);
    else if (c > 0) check_taps("R6 insert", v);
    else if (c < 0) check_taps("R6 swallow", v);
    else           check_taps("R5 zero", v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int pre, mag, adj;
    #(CLK_PERIOD * 3 + 1);
    chk("R1 ticks in reset", int'(tick_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1/R3: from reset, chain at zero and untrimmed
    count_ticks(RUN_N);
    check_taps("R1", RUN_N);

    // R5/R6: full sweep of trim values
    for (int c = -(1 << (CORR_W-1)); c < (1 << (CORR_W-1)); c++) run_trim(c, 1'b1, RUN_N);

    // R4: loaded but disabled
    run_trim(29, 1'b0, RUN_N);
    run_trim(-32, 1'b0, RUN_N);

    // R7: clear mid-run keeps trim and accumulator
    pre = 100;
    mag = 21;
    @(negedge clk);
    wr_i = 1'b1; wr_corr_i = CORR_W'(mag); wr_trim_en_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    for (int i = 0; i < pre; i++) @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    chk("R7 no tick on clear", int'(tick_o), 0);
    adj = ((pre + 1 + RUN_N) * mag) / (1 << WIN_W) - ((pre + 1) * mag) / (1 << WIN_W);
    count_ticks(RUN_N);
    check_taps("R7", RUN_N + adj);

    // R2: every tick is one cycle wide on the fastest tap
    begin
      int wide = 0;
      bit prev = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (tick_o[0] && prev) wide++;
        prev = tick_o[0];
      end
      chk("R2 pulse width", wide, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule